// File: doc/BRIEF.md
# Register-Programmed Video Timing Engine

This block turns a pixel clock into a raster. Software programs the line period, the sync pulse widths and the bounds of the displayed region through a plain word-addressed write/read port. Once the engine is started it drives horizontal sync, vertical sync and a data-enable strobe, and it passes pixel data through to its output. Horizontal positions are pixel offsets within a line. Vertical positions are absolute pixel-clock offsets from the start of the frame. Any hsync skew is therefore already part of the programmed vertical values.

Inside the displayed region, an optional active sub-window can be switched on independently along each axis. Displayed pixels that fall outside an enabled window carry a fixed border colour. Inside the active area the engine requests pixels from a source. When the source has no valid pixel, the engine substitutes an underflow colour and sets a sticky status flag. A fetch-start pulse can be placed at any pixel-clock offset in the frame, to wake upstream logic. Live frame and line counters can be read back.

All timing, window, colour, polarity and fetch settings go to a programmed copy first. A working copy takes them over while the engine is stopped, or at the last pixel clock of a frame, so a running frame is never torn.

Top module: `dte_timing_engine`

## Requirements
- R1: After reset, hsync, vsync, de, pix_out and fetch_start are 0, all registers read 0, and the counters read 0.
- R2: Word 2 holds the line period in bits 31:16 and the hsync width in bits 15:0. The raw hsync is asserted for line positions 0 up to width−1, and the line position wraps after period−1.
- R3: Word 3 holds the frame length in pixel clocks and word 4 the vsync width in pixel clocks. The raw vsync is asserted while the frame position is below the width, and the frame position wraps after length−1.
- R4: The raw de is asserted when the line position is within [word 5 bits 15:0, word 5 bits 31:16] inclusive, and the frame position is within [word 6, word 7] inclusive. Otherwise pix_out is 0.
- R5: Word 1 bit 29 enables the horizontal window, which is word 8 with the end in bits 31:16 and the start in bits 15:0. Word 1 bit 30 enables the vertical window, which runs from word 9 to word 10 in pixel clocks. A displayed pixel outside an enabled window shows the border colour in word 11. A pixel inside the window shows pix_data, and pix_req is high for that pixel.
- R6: When word 1 bit 31 is set, fetch_start pulses for one pixel clock at the frame position given in word 14. Otherwise it stays 0.
- R7: Word 13 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de.
- R8: Writing 1 to word 0 bit 0 starts the engine and writing 0 stops it. While stopped, the counters are held at 0 and the outputs sit at their inactive (polarity-adjusted) levels.
- R9: The frame counter (read word 16) increments on each frame wrap. The line counter (read word 17) counts line wraps and returns to 0 at the frame start.
- R10: When an active pixel finds pix_valid low, pix_out carries the colour in word 12 and status word 18 bit 0 is set. That bit stays set until word 18 is written, and a new underflow in the same cycle wins over the clear.
- R11: While the engine runs, a write to words 1 to 14 takes effect from the next frame start. A write landing in the frame's last pixel clock takes effect one frame later.
- R12: Words 0 to 14 read back the value last written. Unused addresses read 0.
- R13: Every output changes one pixel clock after the counter position it reflects. Counting starts at position 0 on the clock edge after the start write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| pix_valid | input | 1 | Source has a pixel ready |
| pix_data | input | 24 | Source pixel |
| pix_req | output | 1 | Current position consumes a source pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | 24 | Output pixel |
| fetch_start | output | 1 | Programmable fetch pulse |

## Verification
The case that needs the most care is a register write that lands in the same pixel clock as the frame wrap, because the working copy is loaded at that very edge. The bench times a write of a new fetch position to the frame's final position. It then checks that the next frame still pulses at the old offset, and that only the frame after that uses the new one. A second mid-frame write of the border colour shows that the current frame keeps the old colour and the next frame uses the new one. Underflow is provoked at a pixel inside both windows. The bench checks the substituted colour, and that the sticky flag persists after pix_valid returns.

// File: rtl/dte_pkg.sv
package dte_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;
  localparam int HW     = 16;
  localparam int POS_W  = 24;
  localparam int PIX_W  = 24;
  localparam int LINE_W = 16;
  localparam int NPROG  = 15;

  localparam logic [ADDR_W-1:0] A_ENABLE = 5'd0;
  localparam logic [ADDR_W-1:0] A_CFG    = 5'd1;
  localparam logic [ADDR_W-1:0] A_HCTL   = 5'd2;
  localparam logic [ADDR_W-1:0] A_VLEN   = 5'd3;
  localparam logic [ADDR_W-1:0] A_VSW    = 5'd4;
  localparam logic [ADDR_W-1:0] A_DISPH  = 5'd5;
  localparam logic [ADDR_W-1:0] A_DVS    = 5'd6;
  localparam logic [ADDR_W-1:0] A_DVE    = 5'd7;
  localparam logic [ADDR_W-1:0] A_ACTH   = 5'd8;
  localparam logic [ADDR_W-1:0] A_AVS    = 5'd9;
  localparam logic [ADDR_W-1:0] A_AVE    = 5'd10;
  localparam logic [ADDR_W-1:0] A_BORDER = 5'd11;
  localparam logic [ADDR_W-1:0] A_UFLOW  = 5'd12;
  localparam logic [ADDR_W-1:0] A_POL    = 5'd13;
  localparam logic [ADDR_W-1:0] A_FETCH  = 5'd14;
  localparam logic [ADDR_W-1:0] A_FRAME  = 5'd16;
  localparam logic [ADDR_W-1:0] A_LINE   = 5'd17;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'd18;

  typedef struct packed {
    logic              fetch_en;
    logic              win_v_en;
    logic              win_h_en;
    logic [2:0]        pol;
    logic [HW-1:0]     h_period;
    logic [HW-1:0]     h_sw;
    logic [HW-1:0]     d_first;
    logic [HW-1:0]     d_last;
    logic [HW-1:0]     w_hs;
    logic [HW-1:0]     w_he;
    logic [POS_W-1:0]  f_len;
    logic [POS_W-1:0]  v_sw;
    logic [POS_W-1:0]  d_vs;
    logic [POS_W-1:0]  d_ve;
    logic [POS_W-1:0]  w_vs;
    logic [POS_W-1:0]  w_ve;
    logic [POS_W-1:0]  fetch_pos;
    logic [PIX_W-1:0]  border;
    logic [PIX_W-1:0]  uflow;
  } tcfg_t;
endpackage

// File: rtl/dte_regs.sv
module dte_regs
  import dte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              frame_wrap,
  input  logic [REG_W-1:0]  frame_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              uf_set,
  output logic              en,
  output tcfg_t             cfg_s,
  output logic              uf_sticky
);
  logic [REG_W-1:0] prog_q [NPROG];
  logic [NPROG-1:0] we_vec;
  tcfg_t            cfg_n;
  logic             commit;
  logic             uf_clr;
  logic             uf_n;

  genvar gi;
  generate
    for (gi = 0; gi < NPROG; gi++) begin : g_we
      assign we_vec[gi] = wr_en && (wr_addr == ADDR_W'(gi));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPROG; i++) prog_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPROG; i++)
        if (we_vec[i]) prog_q[i] <= wr_data;
    end
  end

  assign en = prog_q[A_ENABLE][0];

  // Decode the programmed words into the working-copy layout
  always_comb begin
    cfg_n           = '0;
    cfg_n.fetch_en  = prog_q[A_CFG][31];
    cfg_n.win_v_en  = prog_q[A_CFG][30];
    cfg_n.win_h_en  = prog_q[A_CFG][29];
    cfg_n.pol       = prog_q[A_POL][2:0];
    cfg_n.h_period  = prog_q[A_HCTL][31:16];
    cfg_n.h_sw      = prog_q[A_HCTL][15:0];
    cfg_n.d_last    = prog_q[A_DISPH][31:16];
    cfg_n.d_first   = prog_q[A_DISPH][15:0];
    cfg_n.w_he      = prog_q[A_ACTH][31:16];
    cfg_n.w_hs      = prog_q[A_ACTH][15:0];
    cfg_n.f_len     = prog_q[A_VLEN][POS_W-1:0];
    cfg_n.v_sw      = prog_q[A_VSW][POS_W-1:0];
    cfg_n.d_vs      = prog_q[A_DVS][POS_W-1:0];
    cfg_n.d_ve      = prog_q[A_DVE][POS_W-1:0];
    cfg_n.w_vs      = prog_q[A_AVS][POS_W-1:0];
    cfg_n.w_ve      = prog_q[A_AVE][POS_W-1:0];
    cfg_n.fetch_pos = prog_q[A_FETCH][POS_W-1:0];
    cfg_n.border    = prog_q[A_BORDER][PIX_W-1:0];
    cfg_n.uflow     = prog_q[A_UFLOW][PIX_W-1:0];
  end

  assign commit = !en || frame_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_s <= '0;
    else if (commit) cfg_s <= cfg_n;
  end

  assign uf_clr = wr_en && (wr_addr == A_STATUS);

  always_comb begin
    uf_n = uf_sticky;
    if (uf_clr) uf_n = 1'b0;
    if (uf_set) uf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_sticky <= 1'b0;
    else        uf_sticky <= uf_n;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(NPROG)) rd_data = prog_q[rd_addr[3:0]];
    else if (rd_addr == A_FRAME)  rd_data = frame_cnt;
    else if (rd_addr == A_LINE)   rd_data = REG_W'(line_cnt);
    else if (rd_addr == A_STATUS) rd_data = REG_W'(uf_sticky);
  end
endmodule

// File: rtl/dte_counters.sv
module dte_counters #(
  parameter int HW     = 16,
  parameter int POS_W  = 24,
  parameter int LINE_W = 16,
  parameter int FC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HW-1:0]     h_period,
  input  logic [POS_W-1:0]  f_len,
  output logic [HW-1:0]     hc,
  output logic [POS_W-1:0]  fc,
  output logic [LINE_W-1:0] line_cnt,
  output logic [FC_W-1:0]   frame_cnt,
  output logic              frame_wrap
);
  logic              h_last;
  logic              f_last;
  logic [HW-1:0]     hc_n;
  logic [POS_W-1:0]  fc_n;
  logic [LINE_W-1:0] line_n;
  logic [FC_W-1:0]   frame_n;

  assign h_last     = (hc == h_period - HW'(1));
  assign f_last     = (fc == f_len - POS_W'(1));
  assign frame_wrap = en && f_last;

  always_comb begin
    hc_n    = hc;
    fc_n    = fc;
    line_n  = line_cnt;
    frame_n = frame_cnt;
    if (!en) begin
      hc_n    = '0;
      fc_n    = '0;
      line_n  = '0;
      frame_n = '0;
    end else if (f_last) begin
      hc_n    = '0;
      fc_n    = '0;
      line_n  = '0;
      frame_n = frame_cnt + FC_W'(1);
    end else begin
      fc_n = fc + POS_W'(1);
      if (h_last) begin
        hc_n   = '0;
        line_n = line_cnt + LINE_W'(1);
      end else begin
        hc_n = hc + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc        <= '0;
      fc        <= '0;
      line_cnt  <= '0;
      frame_cnt <= '0;
    end else begin
      hc        <= hc_n;
      fc        <= fc_n;
      line_cnt  <= line_n;
      frame_cnt <= frame_n;
    end
  end
endmodule

// File: rtl/dte_video.sv
module dte_video
  import dte_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  tcfg_t            cfg,
  input  logic [HW-1:0]    hc,
  input  logic [POS_W-1:0] fc,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_req,
  output logic             uf_set,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [PIX_W-1:0] pix_out,
  output logic             fetch_start
);
  logic             in_dh, in_dv, in_disp;
  logic             in_wh, in_wv, active;
  logic             hs_n, vs_n, de_n, fe_n;
  logic [PIX_W-1:0] pix_n;

  assign in_dh   = (hc >= cfg.d_first) && (hc <= cfg.d_last);
  assign in_dv   = (fc >= cfg.d_vs) && (fc <= cfg.d_ve);
  assign in_disp = en && in_dh && in_dv;
  assign in_wh   = !cfg.win_h_en || ((hc >= cfg.w_hs) && (hc <= cfg.w_he));
  assign in_wv   = !cfg.win_v_en || ((fc >= cfg.w_vs) && (fc <= cfg.w_ve));
  assign active  = in_disp && in_wh && in_wv;
  assign pix_req = active;
  assign uf_set  = active && !pix_valid;

  always_comb begin
    hs_n = (en && (hc < cfg.h_sw)) ^ cfg.pol[0];
    vs_n = (en && (fc < cfg.v_sw)) ^ cfg.pol[1];
    de_n = in_disp ^ cfg.pol[2];
    fe_n = en && cfg.fetch_en && (fc == cfg.fetch_pos);
    if (!in_disp)       pix_n = '0;
    else if (!active)   pix_n = cfg.border;
    else if (pix_valid) pix_n = pix_data;
    else                pix_n = cfg.uflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      de          <= 1'b0;
      pix_out     <= '0;
      fetch_start <= 1'b0;
    end else begin
      hsync       <= hs_n;
      vsync       <= vs_n;
      de          <= de_n;
      pix_out     <= pix_n;
      fetch_start <= fe_n;
    end
  end
endmodule

// File: rtl/dte_timing_engine.sv
module dte_timing_engine
  import dte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              pix_req,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PIX_W-1:0]  pix_out,
  output logic              fetch_start
);
  logic [1:0]        rst_sync;
  logic              rst_s;
  logic              en;
  tcfg_t             cfg_s;
  logic              uf_sticky;
  logic              uf_set;
  logic              frame_wrap;
  logic [HW-1:0]     hc;
  logic [POS_W-1:0]  fc;
  logic [LINE_W-1:0] line_cnt;
  logic [REG_W-1:0]  frame_cnt;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  dte_regs i_regs (
    .clk        (clk),
    .rst_n      (rst_s),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .frame_wrap (frame_wrap),
    .frame_cnt  (frame_cnt),
    .line_cnt   (line_cnt),
    .uf_set     (uf_set),
    .en         (en),
    .cfg_s      (cfg_s),
    .uf_sticky  (uf_sticky)
  );

  dte_counters #(
    .HW     (HW),
    .POS_W  (POS_W),
    .LINE_W (LINE_W),
    .FC_W   (REG_W)
  ) i_cnt (
    .clk        (clk),
    .rst_n      (rst_s),
    .en         (en),
    .h_period   (cfg_s.h_period),
    .f_len      (cfg_s.f_len),
    .hc         (hc),
    .fc         (fc),
    .line_cnt   (line_cnt),
    .frame_cnt  (frame_cnt),
    .frame_wrap (frame_wrap)
  );

  dte_video i_video (
    .clk         (clk),
    .rst_n       (rst_s),
    .en          (en),
    .cfg         (cfg_s),
    .hc          (hc),
    .fc          (fc),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .pix_req     (pix_req),
    .uf_set      (uf_set),
    .hsync       (hsync),
    .vsync       (vsync),
    .de          (de),
    .pix_out     (pix_out),
    .fetch_start (fetch_start)
  );
endmodule

// File: rtl/dte_checker.sv
module dte_checker
  import dte_pkg::*;
(
  input logic              clk,
  input logic              rst_s,
  input logic              en,
  input logic [2:0]        pol,
  input logic              fetch_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              uf_sticky,
  input logic [REG_W-1:0]  frame_cnt,
  input logic [LINE_W-1:0] line_cnt,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic              fetch_start
);
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_s)
    !en |=> (hsync == $past(pol[0])) && (vsync == $past(pol[1])) && (de == $past(pol[2]))); // R8

  AST_COUNTERS_HELD: assert property (@(posedge clk) disable iff (!rst_s)
    !en |=> (frame_cnt == '0) && (line_cnt == '0)); // R8

  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_s)
    (uf_sticky && !(wr_en && (wr_addr == A_STATUS))) |=> uf_sticky); // R10

  AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rst_s)
    fetch_start |-> $past(fetch_en && en)); // R6

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_s)
    (en && $past(en) && (frame_cnt != $past(frame_cnt))) |-> (frame_cnt == $past(frame_cnt) + 1)); // R9
endmodule

bind dte_timing_engine dte_checker i_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .en          (en),
  .pol         (cfg_s.pol),
  .fetch_en    (cfg_s.fetch_en),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .uf_sticky   (uf_sticky),
  .frame_cnt   (frame_cnt),
  .line_cnt    (line_cnt),
  .hsync       (hsync),
  .vsync       (vsync),
  .de          (de),
  .fetch_start (fetch_start)
);

// File: tb/test_dte_timing_engine.sv
`timescale 1ns/1ps
module test_dte_timing_engine;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;
  logic        pix_valid;
  logic [23:0] pix_data;
  logic        pix_req;
  logic        hsync, vsync, de, fetch_start;
  logic [23:0] pix_out;

  int tests, fails, p;
  bit done;

  dte_timing_engine i_dte_timing_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_req(pix_req), .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
    .fetch_start(fetch_start)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Frame: line period 10, hsync 2, display x 3..8, frame 60 clocks,
  // vsync 10 clocks, display 20..49, window x 4..6 and 30..39, fetch at 55.
  typedef struct packed {
    logic [31:0] k;
    logic        hs;
    logic        vs;
    logic        de;
    logic        fe;
    logic [23:0] px;
  } vec_t;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'd0,  1'b1, 1'b1, 1'b0, 1'b0, 24'h0},
    '{32'd1,  1'b1, 1'b1, 1'b0, 1'b0, 24'h0},
    '{32'd2,  1'b0, 1'b1, 1'b0, 1'b0, 24'h0},
    '{32'd10, 1'b1, 1'b0, 1'b0, 1'b0, 24'h0},
    '{32'd12, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0},
    '{32'd23, 1'b0, 1'b0, 1'b1, 1'b0, 24'hBB},
    '{32'd33, 1'b0, 1'b0, 1'b1, 1'b0, 24'hBB},
    '{32'd34, 1'b0, 1'b0, 1'b1, 1'b0, 24'h55},
    '{32'd36, 1'b0, 1'b0, 1'b1, 1'b0, 24'h55},
    '{32'd37, 1'b0, 1'b0, 1'b1, 1'b0, 24'hBB},
    '{32'd38, 1'b0, 1'b0, 1'b1, 1'b0, 24'hBB},
    '{32'd39, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0},
    '{32'd44, 1'b0, 1'b0, 1'b1, 1'b0, 24'hBB},
    '{32'd49, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0},
    '{32'd50, 1'b1, 1'b0, 1'b0, 1'b0, 24'h0},
    '{32'd55, 1'b0, 1'b0, 1'b0, 1'b1, 24'h0},
    '{32'd56, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0},
    '{32'd60, 1'b1, 1'b1, 1'b0, 1'b0, 24'h0}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", what, got, exp);
    end
  endtask

  task automatic write_now(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    p++;
    wr_en = 1'b0;
  endtask

  task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    write_now(a, d);
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_to(input int k);
    while (p < k) begin
      @(negedge clk);
      p++;
    end
  endtask

  initial begin
    logic [31:0] v;
    tests = 0; fails = 0; p = 0; done = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    pix_valid = 1'b1; pix_data = 24'h55;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 hsync", {31'b0, hsync}, 0);
    chk("R1 de", {31'b0, de}, 0);
    chk("R1 pix_out", {8'b0, pix_out}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_reg(5'd1, v);  chk("R1 cfg word", v, 0);
    read_reg(5'd16, v); chk("R1 frame count", v, 0);

    write_reg(5'd2,  32'h000A0002);
    write_reg(5'd3,  32'd60);
    write_reg(5'd4,  32'd10);
    write_reg(5'd5,  32'h00080003);
    write_reg(5'd6,  32'd20);
    write_reg(5'd7,  32'd49);
    write_reg(5'd8,  32'h00060004);
    write_reg(5'd9,  32'd30);
    write_reg(5'd10, 32'd39);
    write_reg(5'd11, 32'hBB);
    write_reg(5'd12, 32'hEE);
    write_reg(5'd14, 32'd55);
    write_reg(5'd1,  32'hE0000000);
    // R12: readback
    read_reg(5'd2, v);  chk("R12 word 2", v, 32'h000A0002);
    read_reg(5'd8, v);  chk("R12 word 8", v, 32'h00060004);
    read_reg(5'd31, v); chk("R12 unused", v, 0);

    // R13: position k appears at the outputs k+1 edges after the start write
    @(negedge clk);
    write_now(5'd0, 32'd1);
    p = -1;
    for (int i = 0; i < NV; i++) begin
      wait_to(int'(VECS[i].k));
      chk($sformatf("R2 hsync k=%0d", VECS[i].k), {31'b0, hsync}, {31'b0, VECS[i].hs});
      chk($sformatf("R3 vsync k=%0d", VECS[i].k), {31'b0, vsync}, {31'b0, VECS[i].vs});
      chk($sformatf("R4 de k=%0d", VECS[i].k), {31'b0, de}, {31'b0, VECS[i].de});
      chk($sformatf("R5 pix k=%0d", VECS[i].k), {8'b0, pix_out}, {8'b0, VECS[i].px});
      chk($sformatf("R6 fetch k=%0d", VECS[i].k), {31'b0, fetch_start}, {31'b0, VECS[i].fe});
    end
    // R9: counters sit one position ahead of the outputs
    read_reg(5'd16, v); chk("R9 frame count", v, 1);
    read_reg(5'd17, v); chk("R9 line at frame start", v, 0);
    wait_to(75);
    read_reg(5'd17, v); chk("R9 line count", v, 1);

    // R11: write on the last clock of frame 1 waits a full frame
    wait_to(118);
    write_now(5'd14, 32'd15);
    wait_to(135); chk("R11 new fetch not yet", {31'b0, fetch_start}, 0);
    wait_to(175); chk("R11 old fetch kept", {31'b0, fetch_start}, 1);
    wait_to(182);
    write_now(5'd11, 32'hCC);
    wait_to(195); chk("R11 new fetch used", {31'b0, fetch_start}, 1);
    wait_to(203); chk("R11 border held mid-frame", {8'b0, pix_out}, 32'hBB);
    wait_to(263); chk("R11 border next frame", {8'b0, pix_out}, 32'hCC);

    // R10: underflow
    wait_to(270);
    pix_valid = 1'b0;
    wait_to(275); chk("R10 underflow colour", {8'b0, pix_out}, 32'hEE);
    pix_valid = 1'b1;
    wait_to(300);
    read_reg(5'd18, v); chk("R10 sticky set", v, 1);
    write_now(5'd18, 32'd0);
    read_reg(5'd18, v); chk("R10 sticky cleared", v, 0);

    // R8: stop
    write_now(5'd0, 32'd0);
    @(negedge clk);
    read_reg(5'd16, v); chk("R8 frame count off", v, 0);
    read_reg(5'd17, v); chk("R8 line count off", v, 0);
    chk("R8 de inactive", {31'b0, de}, 0);
    chk("R8 pix zero", {8'b0, pix_out}, 0);

    // R7: polarity
    write_reg(5'd13, 32'd7);
    repeat (3) @(negedge clk);
    chk("R7 idle hsync inverted", {31'b0, hsync}, 1);
    chk("R7 idle de inverted", {31'b0, de}, 1);
    write_now(5'd0, 32'd1);
    p = -1;
    wait_to(0);
    chk("R7 hsync active low", {31'b0, hsync}, 0);
    chk("R7 vsync active low", {31'b0, vsync}, 0);
    wait_to(23);
    chk("R7 de active low", {31'b0, de}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule